// File: doc/BRIEF.md
# Two-Rule Serial Output Switcher

This block watches a serial bit stream, one bit per clock, and drives a single output bit through one of two output rules. In the follow rule the output repeats the bit received on the previous clock. In the invert rule the output is the complement of the bit present now. The output is combinational from the current input and the stored state, so it changes within the same cycle as the input.

The block starts in the follow rule. When the last bits received, oldest first, form the entry pattern (0, 0, 1 by default), the block moves to the invert rule. When they form the exit pattern (1, 0, 0 by default), it returns to the follow rule. The bit that completes a pattern is still shaped by the rule in force. The new rule takes effect from the next bit. A pattern may reuse bits that arrived before the previous switch. Both patterns and their length are parameters.

Top module: `rule_switch_detector`

## Requirements
- R1: While `rst` is high on a rising edge, the block returns to the follow rule and clears its history. In the first cycle after reset, `z_out` is 0 whatever `x_in` is.
- R2: In the follow rule, outside the first cycle after reset, `z_out` equals the `x_in` value sampled at the previous rising edge.
- R3: In the invert rule, `z_out` equals the complement of the current `x_in`.
- R4: In the follow rule, when the bit sampled now completes the entry pattern (0,0,1 with the oldest bit first), the block uses the invert rule from the next bit on. The completing bit is still output under the follow rule.
- R5: In the invert rule, when the bit sampled now completes the exit pattern (1,0,0 with the oldest bit first), the block uses the follow rule from the next bit on. The completing bit is still output under the invert rule.
- R6: Pattern windows span rule switches. The stream 0,0,1,0,0 after reset enters the invert rule and then leaves it on the fifth bit. After an exit, the stream ...1,0,0,1 enters the invert rule again on the last 1.
- R7: A pattern is recognised only from bits received since the last reset. Bits 0,1 directly after reset do not enter the invert rule.
- R8: In the follow rule the exit pattern has no effect, and the rule only changes on the entry pattern. In the invert rule the rule only changes on the exit pattern.
- R9: For the input stream 1,0,0,1,1,0,1,0,0,0,1,1 after reset, `z_out` is 0,1,0,0,0,1,0,1,1,0,0,0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 1 | Serial input bit, one per clock |
| z_out | output | 1 | Output bit under the rule in force (combinational) |

## Verification
The checks that run on every cycle cover four things: the output law of each rule (previous bit, or complement of the current bit), the zero output on the first cycle after reset, and the rule switching only on a recognised pattern. A set of overlapping streams, the stated example, and the reset-window case show which bit completes a pattern and whether bits from before a switch or before reset count. These are shown only by the bench's scenarios: an exhaustive sweep of every 10-bit stream from reset, a long random stream, and resets in mid-stream, all compared against a bit-level model.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

   typedef enum logic {
      RULE_FOLLOW = 1'b0,
      RULE_INVERT = 1'b1
   } rule_e;

endpackage

// File: rtl/rsd_history.sv
module rsd_history #(
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             x_in,
   output logic [DEPTH-1:0] hist,
   output logic             full
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] fill_q;

   if (DEPTH < 1) begin : g_bad_depth
      $error("rsd_history: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (rst) hist <= '0;
         else     hist <= x_in;
      end
   end else begin : g_shift
      always_ff @(posedge clk) begin
         if (rst) hist <= '0;
         else     hist <= {hist[DEPTH-2:0], x_in};
      end
   end

   always_ff @(posedge clk) begin
      if (rst)                        fill_q <= '0;
      else if (fill_q != CW'(DEPTH))  fill_q <= fill_q + CW'(1);
   end

   assign full = (fill_q == CW'(DEPTH));

endmodule

// File: rtl/rsd_matcher.sv
module rsd_matcher #(
   parameter int               LEN = 3,
   parameter logic [LEN-1:0]   PAT = '0
) (
   input  logic [LEN-1:0] window,
   input  logic           window_ok,
   output logic           hit
);
   logic [LEN-1:0] bit_eq;

   for (genvar i = 0; i < LEN; i++) begin : g_cmp
      assign bit_eq[i] = ~(window[i] ^ PAT[i]);
   end

   assign hit = window_ok & (&bit_eq);

endmodule

// File: rtl/rsd_rule_ctrl.sv
module rsd_rule_ctrl
   import rsd_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  enter_hit,
   input  logic  exit_hit,
   output rule_e mode_q
);
   rule_e mode_d;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         RULE_FOLLOW: if (enter_hit) mode_d = RULE_INVERT;
         RULE_INVERT: if (exit_hit)  mode_d = RULE_FOLLOW;
         default:                    mode_d = RULE_FOLLOW;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) mode_q <= RULE_FOLLOW;
      else     mode_q <= mode_d;
   end

endmodule

// File: rtl/rule_switch_detector.sv
module rule_switch_detector
   import rsd_pkg::*;
#(
   parameter int             PAT_LEN   = 3,
   parameter logic [PAT_LEN-1:0] ENTER_PAT = 3'b001,
   parameter logic [PAT_LEN-1:0] EXIT_PAT  = 3'b100
) (
   input  logic clk,
   input  logic rst,
   input  logic x_in,
   output logic z_out
);
   localparam int HIST_W = PAT_LEN - 1;

   if (PAT_LEN < 2) begin : g_bad_len
      $error("rule_switch_detector: PAT_LEN must be at least 2");
   end
   if (ENTER_PAT == EXIT_PAT) begin : g_bad_pat
      $error("rule_switch_detector: entry and exit patterns must differ");
   end

   logic [HIST_W-1:0]  hist;
   logic               hist_full;
   logic [PAT_LEN-1:0] window;
   logic               enter_hit;
   logic               exit_hit;
   logic               prev_x;
   rule_e              mode_q;

   rsd_history #(.DEPTH(HIST_W)) u_hist (
      .clk  (clk),
      .rst  (rst),
      .x_in (x_in),
      .hist (hist),
      .full (hist_full)
   );

   // oldest bit in the MSB, current bit in the LSB
   assign window = {hist, x_in};
   assign prev_x = hist[0];

   rsd_matcher #(.LEN(PAT_LEN), .PAT(ENTER_PAT)) u_enter (
      .window    (window),
      .window_ok (hist_full),
      .hit       (enter_hit)
   );

   rsd_matcher #(.LEN(PAT_LEN), .PAT(EXIT_PAT)) u_exit (
      .window    (window),
      .window_ok (hist_full),
      .hit       (exit_hit)
   );

   rsd_rule_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .enter_hit (enter_hit),
      .exit_hit  (exit_hit),
      .mode_q    (mode_q)
   );

   always_comb begin
      unique case (mode_q)
         RULE_INVERT: z_out = ~x_in;
         default:     z_out = prev_x;
      endcase
   end

endmodule

// File: rtl/rsd_checker.sv
module rsd_checker
   import rsd_pkg::*;
(
   input logic  clk,
   input logic  rst,
   input logic  x_in,
   input logic  z_out,
   input rule_e mode_q,
   input logic  enter_hit,
   input logic  exit_hit
);

   AST_FIRST_Z_ZERO: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (z_out == 1'b0)); // R1

   AST_FOLLOW_PREV: assert property (@(posedge clk) disable iff (rst)
      (mode_q == RULE_FOLLOW && !$past(rst)) |-> (z_out == $past(x_in))); // R2

   AST_INVERT_NOW: assert property (@(posedge clk) disable iff (rst)
      (mode_q == RULE_INVERT) |-> (z_out == !x_in)); // R3

   AST_ENTER_SWITCH: assert property (@(posedge clk) disable iff (rst)
      (mode_q == RULE_FOLLOW && enter_hit) |=> (mode_q == RULE_INVERT)); // R4

   AST_EXIT_SWITCH: assert property (@(posedge clk) disable iff (rst)
      (mode_q == RULE_INVERT && exit_hit) |=> (mode_q == RULE_FOLLOW)); // R5

   AST_FOLLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mode_q == RULE_FOLLOW && !enter_hit) |=> (mode_q == RULE_FOLLOW)); // R8

   AST_INVERT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mode_q == RULE_INVERT && !exit_hit) |=> (mode_q == RULE_INVERT)); // R8

endmodule

bind rule_switch_detector rsd_checker u_rsd_checker (
   .clk       (clk),
   .rst       (rst),
   .x_in      (x_in),
   .z_out     (z_out),
   .mode_q    (mode_q),
   .enter_hit (enter_hit),
   .exit_hit  (exit_hit)
);

// File: tb/rule_switch_detector_test.sv
module rule_switch_detector_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic x_in = 1'b0;
   logic z_out;

   always #5 clk = ~clk;

   rule_switch_detector uut (
      .clk   (clk),
      .rst   (rst),
      .x_in  (x_in),
      .z_out (z_out)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bit-level model: two prior bits, count since reset, rule, previous bit
   logic [1:0] rh;
   int         rcnt;
   bit         rrule;
   bit         rprev;

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: z_out=%b expected %b", tag, act, exp);
      end
   endtask

   task automatic model_update(input logic b);
      logic [2:0] win;
      win = {rh, b};
      if (rcnt >= 2) begin
         if (!rrule && win == 3'b001)      rrule = 1'b1;
         else if (rrule && win == 3'b100)  rrule = 1'b0;
      end
      rh    = {rh[0], b};
      rprev = b;
      if (rcnt < 2) rcnt++;
   endtask

   // starts and ends at a falling edge; rst is low on return
   task automatic do_reset();
      @(negedge clk);
      rst  = 1'b1;
      x_in = 1'b0;
      @(negedge clk);
      rst   = 1'b0;
      rh    = 2'b00;
      rcnt  = 0;
      rrule = 1'b0;
      rprev = 1'b0;
   endtask

   task automatic step(input logic b);
      logic  exp;
      string tag;
      exp = rrule ? ~b : rprev;
      if (rcnt == 0)  tag = "R1";
      else if (rrule) tag = "R3";
      else            tag = "R2";
      x_in = b;
      #2;
      chk(z_out, exp, tag);
      model_update(b);
      @(negedge clk);
   endtask

   task automatic step_exp(input logic b, input logic exp, input string tag);
      x_in = b;
      #2;
      chk(z_out, exp, tag);
      model_update(b);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL all: watchdog expired, run incomplete, expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [11:0] ex_x;
      logic [11:0] ex_z;

      // R1: reset state, first output is 0 with x_in high
      do_reset();
      step_exp(1'b1, 1'b0, "R1 first output after reset");

      // R7: bits before reset do not complete the entry pattern
      do_reset();
      step_exp(1'b0, 1'b0, "R7");
      step_exp(1'b1, 1'b0, "R7");
      step_exp(1'b1, 1'b1, "R7 no entry from pre-reset bits");

      // R4 then R5
      do_reset();
      step_exp(1'b0, 1'b0, "R4");
      step_exp(1'b0, 1'b0, "R4");
      step_exp(1'b1, 1'b0, "R4 completing bit");
      step_exp(1'b1, 1'b0, "R4 invert rule after entry");
      step_exp(1'b0, 1'b1, "R5");
      step_exp(1'b0, 1'b1, "R5 completing bit under invert rule");
      step_exp(1'b0, 1'b0, "R5 follow rule after exit");

      // R6: overlap across switches
      do_reset();
      step_exp(1'b0, 1'b0, "R6");
      step_exp(1'b0, 1'b0, "R6");
      step_exp(1'b1, 1'b0, "R6");
      step_exp(1'b0, 1'b1, "R6");
      step_exp(1'b0, 1'b1, "R6 exit completed on shared bits");
      step_exp(1'b0, 1'b0, "R6 exit shares bit with entry");
      step_exp(1'b1, 1'b0, "R6");
      step_exp(1'b1, 1'b0, "R6 re-entry shares bits with exit");

      // R8: exit pattern ignored in follow rule
      do_reset();
      step_exp(1'b1, 1'b0, "R8");
      step_exp(1'b0, 1'b1, "R8");
      step_exp(1'b0, 1'b0, "R8");
      step_exp(1'b0, 1'b0, "R8 exit pattern ignored in follow rule");

      // R9: worked example
      ex_x = 12'b1001_1010_0011;
      ex_z = 12'b0100_0101_1000;
      do_reset();
      for (int i = 11; i >= 0; i--) step_exp(ex_x[i], ex_z[i], "R9 example stream");

      // exhaustive sweep of all 10-bit streams from reset (R2, R3, R4, R5, R6)
      for (int s = 0; s < 1024; s++) begin
         do_reset();
         for (int i = 0; i < 10; i++) step(logic'((s >> i) & 1));
      end

      // long random stream with occasional mid-stream resets (R1, R2, R3)
      do_reset();
      for (int n = 0; n < 4000; n++) begin
         if (n % 997 == 996) do_reset();
         step(logic'($urandom & 1));
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule